// File: doc/BRIEF.md
# Serial Bus Master Register Front End

This block is the host-facing register window of a single-wire serial bus master. The master reads and writes 8-bit registers in a remote device. Software writes one command word. That word holds the transfer direction, the low address byte and, for writes, the data byte. Software then polls a status word until the transfer has finished. For a read, software collects the returned byte from a read-data register. The seven upper address bits are kept in a separate mode register, so a run of accesses inside one 256-byte page needs no extra setup.

The serial line itself is modelled, not encoded. A transfer engine holds the bus for a fixed number of clock cycles and then commits the access to an internal remote register file. The engine is a three-state machine:

- **IDLE**: ready for a command.
- **SHIFT**: counts out the transfer time.
- **FINISH**: one cycle in which the remote access is made.

It has four transitions:

- IDLE→SHIFT when a command is accepted.
- SHIFT→SHIFT while the transfer counter is non-zero.
- SHIFT→FINISH when the counter reaches zero.
- FINISH→IDLE always.

Every remote access is also shown on link output pins for one cycle.

Top module: `sbm_regfront`

## Requirements
- R1: Host byte offsets are 0x08 command, 0x10 read data, 0x14 status and 0x1C mode. Any other offset reads as zero. A write to any other offset changes no state.
- R2: Status bit 0 is busy, bit 1 is ready and bit 2 is read-data-ready, and bits 31:3 read zero. After reset, status reads 0x2, read data reads 0 and the mode register holds only its fixed low nibble.
- R3: A command write while ready shows busy=1, ready=0 from the next cycle onward. Busy lasts exactly XFER_CYCLES+1 cycles (251 by default, about 5 us at 50 MHz), and then ready returns.
- R4: In the command word, bit 24 set means read and clear means write. Bits 23:16 are the low address byte and bits 7:0 are the write data.
- R5: The 15-bit remote address is {mode[10:4], command[23:16]}, taken at the moment the command is accepted. A mode write during the transfer does not change it.
- R6: A mode write loads bits 10:4 from the written word. Bits 3:0 keep their fixed value (MODE_LOW, default 0x5), and bits 31:11 read zero.
- R7: A completed read puts the remote byte in read-data bits 7:0, with bits 31:8 zero. Read-data-ready sets in the same cycle that busy clears.
- R8: Read-data-ready clears on a host read of offset 0x10 or on an accepted command. If completion and a read of 0x10 fall on the same edge, the flag ends up set.
- R9: A command write while busy is ignored. Status, the transfer in flight and its address and data stay unchanged.
- R10: Busy never stays high for more than TIMEOUT_CYCLES cycles (5000, which is 100 us).
- R11: link_strobe is high for exactly one cycle, the last busy cycle, and carries the address, direction and write data. The remote file decodes the low REMOTE_AW (8) address bits, stores written bytes and resets to all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (side effect on offset 0x10) |
| host_addr | input | 8 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Combinational read data for host_addr |
| link_strobe | output | 1 | One-cycle remote access marker |
| link_rnw | output | 1 | Direction of the access (1 = read) |
| link_addr | output | 15 | Full remote address |
| link_wdata | output | 8 | Write byte of the access |

## Verification
The assertions assume that the host raises at most one of host_wr and host_rd in a cycle, and that every input is steady around the rising edge. The bench meets both conditions by driving all inputs on the falling edge, one access per cycle. The timeout property also assumes XFER_CYCLES+1 does not exceed TIMEOUT_CYCLES. The bench uses the default values, which satisfy this. Stimulus includes commands aimed at a busy engine, mode writes during a transfer, and a read of the read-data register held across the completion edge, so the ignore rule and the set-wins rule are actually reached.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

    localparam int HOST_AW = 8;
    localparam int HOST_DW = 32;
    localparam int LOW_AW  = 8;
    localparam int HI_AW   = 7;
    localparam int FULL_AW = LOW_AW + HI_AW;
    localparam int BYTE_W  = 8;

    localparam logic [HOST_AW-1:0] OFS_CMD    = 8'h08;
    localparam logic [HOST_AW-1:0] OFS_RDATA  = 8'h10;
    localparam logic [HOST_AW-1:0] OFS_STATUS = 8'h14;
    localparam logic [HOST_AW-1:0] OFS_MODE   = 8'h1C;

    localparam int CMD_RNW_BIT  = 24;
    localparam int CMD_ADDR_LSB = 16;
    localparam int MODE_HI_LSB  = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_FINISH = 2'd2
    } xfer_state_e;

    typedef struct packed {
        logic               rnw;
        logic [FULL_AW-1:0] addr;
        logic [BYTE_W-1:0]  wdata;
    } xfer_req_t;

endpackage

// File: rtl/sbm_host_regs.sv
module sbm_host_regs
    import sbm_pkg::*;
#(
    parameter logic [3:0] MODE_LOW = 4'h5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    input  logic               st_busy,
    input  logic               st_ready,
    input  logic               st_rdr,
    input  logic [BYTE_W-1:0]  rd_byte,
    output logic               cmd_go,
    output logic               rd_pop,
    output xfer_req_t          new_req
);

    localparam int PAD_MODE = HOST_DW - HI_AW - 4;
    localparam int PAD_STAT = HOST_DW - 3;
    localparam int PAD_RD   = HOST_DW - BYTE_W;

    logic [HI_AW-1:0] mode_hi_q;
    logic             mode_wr;
    logic             unused_wbits;

    assign cmd_go  = host_wr && (host_addr == OFS_CMD);
    assign mode_wr = host_wr && (host_addr == OFS_MODE);
    assign rd_pop  = host_rd && (host_addr == OFS_RDATA);

    assign unused_wbits = ^{host_wdata[HOST_DW-1:CMD_RNW_BIT+1],
                            host_wdata[CMD_ADDR_LSB-1:MODE_HI_LSB+HI_AW]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_hi_q <= '0;
        end else if (mode_wr) begin
            mode_hi_q <= host_wdata[MODE_HI_LSB +: HI_AW];
        end
    end

    always_comb begin
        new_req.rnw   = host_wdata[CMD_RNW_BIT];
        new_req.addr  = {mode_hi_q, host_wdata[CMD_ADDR_LSB +: LOW_AW]};
        new_req.wdata = host_wdata[BYTE_W-1:0];
    end

    always_comb begin
        case (host_addr)
            OFS_RDATA:  host_rdata = {{PAD_RD{1'b0}}, rd_byte};
            OFS_STATUS: host_rdata = {{PAD_STAT{1'b0}}, st_rdr, st_ready, st_busy};
            OFS_MODE:   host_rdata = {{PAD_MODE{1'b0}}, mode_hi_q, MODE_LOW};
            default:    host_rdata = '0;
        endcase
    end

    // R6
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr |=> $stable(mode_hi_q));

    // R1
    one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_rd));

endmodule

// File: rtl/sbm_xfer_engine.sv
module sbm_xfer_engine
    import sbm_pkg::*;
#(
    parameter int XFER_CYCLES    = 250,
    parameter int TIMEOUT_CYCLES = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_go,
    input  xfer_req_t         new_req,
    input  logic              rd_pop,
    input  logic [BYTE_W-1:0] rmt_byte,
    output logic              busy,
    output logic              ready,
    output logic              rdr,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              link_strobe,
    output xfer_req_t         link_req
);

    localparam int CW = $clog2(XFER_CYCLES + 1);
    localparam int RW = $clog2(TIMEOUT_CYCLES + 2);

    xfer_state_e     state_q, state_d;
    logic [CW-1:0]   cnt_q;
    xfer_req_t       req_q;
    logic            accept;
    logic            commit;
    logic [RW-1:0]   run_q;

    assign accept = cmd_go && (state_q == ST_IDLE);
    assign commit = (state_q == ST_FINISH);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_go) state_d = ST_SHIFT;
            ST_SHIFT:  if (cnt_q == '0) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        busy        = 1'b1;
        ready       = 1'b0;
        link_strobe = 1'b0;
        unique case (state_q)
            ST_IDLE:   begin busy = 1'b0; ready = 1'b1; end
            ST_SHIFT:  ;
            ST_FINISH: link_strobe = 1'b1;
            default:   ;
        endcase
    end

    assign link_req = req_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            req_q <= '0;
        end else if (accept) begin
            cnt_q <= CW'(XFER_CYCLES - 1);
            req_q <= new_req;
        end else if ((state_q == ST_SHIFT) && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdr     <= 1'b0;
            rd_byte <= '0;
        end else if (accept) begin
            rdr <= 1'b0;
        end else begin
            if (rd_pop) rdr <= 1'b0;
            if (commit && req_q.rnw) begin
                rdr     <= 1'b1;
                rd_byte <= rmt_byte;
            end
        end
    end

    // busy run-length counter for the timeout bound
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               run_q <= '0;
        else if (!busy)           run_q <= '0;
        else if (run_q != '1)     run_q <= run_q + 1'b1;
    end

    // R3
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && ready) |=> (busy && !ready && !rdr));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && busy) |=> $stable(req_q));

    // R10
    timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RW'(TIMEOUT_CYCLES));

    // R11
    strobe_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_strobe |=> (!busy && !link_strobe));

    // R8
    rdr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdr) |-> $past(link_strobe && link_req.rnw));

endmodule

// File: rtl/sbm_remote_file.sv
module sbm_remote_file
    import sbm_pkg::*;
#(
    parameter int REMOTE_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  xfer_req_t         req,
    output logic [BYTE_W-1:0] rmt_byte
);

    localparam int DEPTH = 1 << REMOTE_AW;

    logic [BYTE_W-1:0]    mem_q [DEPTH];
    logic [REMOTE_AW-1:0] idx;
    logic                 unused_hi;

    assign idx       = req.addr[REMOTE_AW-1:0];
    assign unused_hi = ^req.addr[FULL_AW-1:REMOTE_AW];
    assign rmt_byte  = mem_q[idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (strobe && !req.rnw) begin
            mem_q[idx] <= req.wdata;
        end
    end

    // R11
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !req.rnw) |=> (mem_q[$past(idx)] == $past(req.wdata)));

endmodule

// File: rtl/sbm_regfront.sv
module sbm_regfront
    import sbm_pkg::*;
#(
    parameter int         XFER_CYCLES    = 250,
    parameter int         TIMEOUT_CYCLES = 5000,
    parameter logic [3:0] MODE_LOW       = 4'h5,
    parameter int         REMOTE_AW      = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [7:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        link_strobe,
    output logic        link_rnw,
    output logic [14:0] link_addr,
    output logic [7:0]  link_wdata
);

    logic              cmd_go, rd_pop;
    logic              st_busy, st_ready, st_rdr;
    logic [BYTE_W-1:0] rd_byte, rmt_byte;
    xfer_req_t         new_req, link_req;

    sbm_host_regs #(.MODE_LOW(MODE_LOW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .st_busy    (st_busy),
        .st_ready   (st_ready),
        .st_rdr     (st_rdr),
        .rd_byte    (rd_byte),
        .cmd_go     (cmd_go),
        .rd_pop     (rd_pop),
        .new_req    (new_req)
    );

    sbm_xfer_engine #(
        .XFER_CYCLES    (XFER_CYCLES),
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_go      (cmd_go),
        .new_req     (new_req),
        .rd_pop      (rd_pop),
        .rmt_byte    (rmt_byte),
        .busy        (st_busy),
        .ready       (st_ready),
        .rdr         (st_rdr),
        .rd_byte     (rd_byte),
        .link_strobe (link_strobe),
        .link_req    (link_req)
    );

    sbm_remote_file #(.REMOTE_AW(REMOTE_AW)) u_remote (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (link_strobe),
        .req      (link_req),
        .rmt_byte (rmt_byte)
    );

    assign link_rnw   = link_req.rnw;
    assign link_addr  = link_req.addr;
    assign link_wdata = link_req.wdata;

endmodule

// File: tb/sbm_regfront_test.sv
module sbm_regfront_test;

    localparam int         XFER     = 250;
    localparam int         TIMEOUT  = 5000;
    localparam logic [3:0] MLOW     = 4'h5;
    localparam logic [7:0] A_CMD    = 8'h08;
    localparam logic [7:0] A_RD     = 8'h10;
    localparam logic [7:0] A_STAT   = 8'h14;
    localparam logic [7:0] A_MODE   = 8'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_wr = 1'b0, h_rd = 1'b0;
    logic [7:0]  h_addr = 8'h00;
    logic [31:0] h_wdata = 32'h0;
    logic [31:0] host_rdata;
    logic        link_strobe, link_rnw;
    logic [14:0] link_addr;
    logic [7:0]  link_wdata;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    sbm_regfront uut (
        .clk(clk), .rst_n(rst_n), .host_wr(h_wr), .host_rd(h_rd),
        .host_addr(h_addr), .host_wdata(h_wdata), .host_rdata(host_rdata),
        .link_strobe(link_strobe), .link_rnw(link_rnw),
        .link_addr(link_addr), .link_wdata(link_wdata)
    );

    // behavioural reference model
    int          m_cnt;
    logic        m_rnw, m_rdr, m_acc, m_fin;
    logic [14:0] m_addr;
    logic [7:0]  m_wd, m_rd;
    logic [6:0]  m_hi;
    logic [7:0]  m_mem [256];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_rnw = 0; m_rdr = 0; m_addr = 0; m_wd = 0; m_rd = 0; m_hi = 0;
            for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
        end else begin
            m_acc = h_wr && (h_addr == A_CMD) && (m_cnt == 0);
            m_fin = (m_cnt == 1);
            if (m_fin) begin
                if (m_rnw) m_rd = m_mem[m_addr[7:0]];
                else       m_mem[m_addr[7:0]] = m_wd;
            end
            if (m_acc) m_rdr = 0;
            else begin
                if (h_rd && (h_addr == A_RD)) m_rdr = 0;
                if (m_fin && m_rnw) m_rdr = 1;
            end
            if (m_cnt > 0) m_cnt = m_cnt - 1;
            if (m_acc) begin
                m_cnt  = XFER + 1;
                m_rnw  = h_wdata[24];
                m_addr = {m_hi, h_wdata[23:16]};
                m_wd   = h_wdata[7:0];
            end
            if (h_wr && (h_addr == A_MODE)) m_hi = h_wdata[10:4];
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] model_rdata(input logic [7:0] a);
        case (a)
            A_RD:    return {24'h0, m_rd};
            A_STAT:  return {29'h0, m_rdr, (m_cnt == 0), (m_cnt != 0)};
            A_MODE:  return {21'h0, m_hi, MLOW};
            default: return 32'h0;
        endcase
    endfunction

    // per-cycle comparison, after outputs settle
    always @(posedge clk) begin
        #2;
        if (!done) begin
            case (h_addr)
                A_STAT:  check("R2 status per cycle", host_rdata, model_rdata(h_addr));
                A_RD:    check("R7 read data per cycle", host_rdata, model_rdata(h_addr));
                A_MODE:  check("R6 mode per cycle", host_rdata, model_rdata(h_addr));
                default: check("R1 unmapped per cycle", host_rdata, model_rdata(h_addr));
            endcase
            check("R11 strobe per cycle", {31'h0, link_strobe}, {31'h0, (m_cnt == 1)});
            if (m_cnt == 1) begin
                check("R5 link address", {17'h0, link_addr}, {17'h0, m_addr});
                check("R4 link direction", {31'h0, link_rnw}, {31'h0, m_rnw});
                if (!m_rnw) check("R4 link write data", {24'h0, link_wdata}, {24'h0, m_wd});
            end
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        h_wr = 1'b1; h_rd = 1'b0; h_addr = a; h_wdata = d;
        @(negedge clk);
        h_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        h_rd = 1'b1; h_wr = 1'b0; h_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        h_rd = 1'b0;
    endtask

    task automatic wait_ready(output int n, output logic [14:0] seen);
        h_addr = A_STAT; h_rd = 1'b0; n = 0; seen = '0;
        for (int i = 0; i < TIMEOUT + 10; i++) begin
            @(negedge clk);
            n++;
            #1;
            if (link_strobe) seen = link_addr;
            if (host_rdata[1]) break;
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [14:0] seen;
        int n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        bus_rd(A_STAT, d); check("R2 reset status", d, 32'h2);
        bus_rd(A_RD, d);   check("R2 reset read data", d, 32'h0);
        bus_rd(A_MODE, d); check("R6 reset mode", d, {28'h0, MLOW});
        // R1 unmapped offsets
        bus_rd(8'h00, d);  check("R1 offset 0x00", d, 32'h0);
        bus_rd(8'h0C, d);  check("R1 offset 0x0C", d, 32'h0);

        // R6 mode write keeps low nibble
        bus_wr(A_MODE, 32'hFFFF_FFFF);
        bus_rd(A_MODE, d); check("R6 mode all ones", d, 32'h0000_07F5);
        bus_wr(A_MODE, 32'h0000_002A);
        bus_rd(A_MODE, d); check("R6 mode page 2", d, 32'h0000_0025);

        // R3/R4/R5/R10 write 0x3C to 0x2A5
        bus_wr(A_CMD, 32'h00A5_003C);
        #1 check("R3 busy after accept", host_rdata, 32'h0);
        h_addr = A_STAT; #1 check("R3 status busy", host_rdata, 32'h1);
        wait_ready(n, seen);
        check("R3 busy length", n, XFER + 1);
        check("R10 within bound", {31'h0, (n <= TIMEOUT)}, 32'h1);
        check("R5 full address", {17'h0, seen}, 32'h0000_02A5);

        // R7 read back
        bus_wr(A_CMD, 32'h01A5_0000);
        wait_ready(n, seen);
        bus_rd(A_STAT, d); check("R7 read-data-ready set", d, 32'h6);
        bus_rd(A_RD, d);   check("R7 returned byte", d, 32'h0000_003C);
        bus_rd(A_STAT, d); check("R8 cleared by data read", d, 32'h2);

        // R9 command while busy ignored
        bus_wr(A_CMD, 32'h00A5_0077);
        bus_wr(A_CMD, 32'h0111_0099);
        h_addr = A_STAT; #1 check("R9 status unchanged", host_rdata, 32'h1);
        wait_ready(n, seen);
        check("R9 in-flight address kept", {17'h0, seen}, 32'h0000_02A5);
        bus_rd(A_STAT, d); check("R9 no read performed", d, 32'h2);
        bus_wr(A_CMD, 32'h01A5_0000);
        wait_ready(n, seen);
        bus_rd(A_RD, d); check("R9 first write landed", d, 32'h0000_0077);

        // R5 mode change during transfer
        bus_wr(A_CMD, 32'h0010_00C3);
        bus_wr(A_MODE, 32'h0000_07F0);
        wait_ready(n, seen);
        check("R5 captured page", {17'h0, seen}, 32'h0000_0210);
        // R11 aliasing through low bits: 0x7F10 reads 0x210's byte
        bus_wr(A_CMD, 32'h0110_0000);
        wait_ready(n, seen);
        check("R11 alias address", {17'h0, seen}, 32'h0000_7F10);
        bus_rd(A_RD, d); check("R11 stored byte", d, 32'h0000_00C3);

        // R8 accepted command clears read-data-ready
        bus_wr(A_CMD, 32'h0133_0000);
        wait_ready(n, seen);
        bus_rd(A_RD, d); check("R11 reset contents zero", d, 32'h0);
        bus_wr(A_CMD, 32'h0133_0000);
        wait_ready(n, seen);
        bus_wr(A_CMD, 32'h0044_0011);
        h_addr = A_STAT; #1 check("R8 cleared by command", host_rdata, 32'h1);
        wait_ready(n, seen);

        // R8 completion coincides with data read: set wins
        bus_wr(A_CMD, 32'h0144_0000);
        h_addr = A_RD; h_rd = 1'b1;
        for (int i = 0; i < TIMEOUT; i++) begin
            @(negedge clk);
            #1;
            if (link_strobe) break;
        end
        @(negedge clk);
        h_rd = 1'b0; h_addr = A_STAT;
        #1 check("R8 set wins", host_rdata, 32'h6);
        bus_rd(A_RD, d); check("R7 byte after coincidence", d, 32'h0000_0011);

        // R1 writes to unmapped offsets change nothing
        bus_wr(8'h0C, 32'hFFFF_FFFF);
        bus_wr(8'h18, 32'h01FF_FFFF);
        bus_rd(A_STAT, d); check("R1 status untouched", d, 32'h2);
        bus_rd(A_MODE, d); check("R1 mode untouched", d, 32'h0000_07F5);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule